// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous user port and an external asynchronous 8K x 8 static RAM. It takes single-byte read or write requests and turns each one into a sequence of address, select, output-enable, write-enable and data-driver levels. Every pin holds long enough to meet the RAM's nanosecond limits. All timing comes from parameters: each nanosecond limit is divided by the clock period, rounded up and clamped to at least one cycle. Nothing in the sequencing is fixed to one speed grade.

The user port is a valid/ready request channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The address, direction and write byte are latched on that edge. While `req_ready` is low the requester must hold `req_valid` and the fields steady. The block has one request outstanding at a time, so `req_ready` stays low until the memory has gone back to standby. Read data comes back on a one-cycle `rd_valid` strobe that has no back-pressure.

On the memory side the block drives a select pair with opposite polarities (`mem_sel_n` low together with `mem_sel_p` high selects the device), an active-low read enable and an active-low write enable. The shared data bus is modelled as separate out and in vectors plus a driver enable. The read enable stays high for the whole of every write. The block turns on its own data drivers only after the write enable has gone low, so the bus never has two drivers.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and between requests, the memory is in standby: `mem_sel_n`=1, `mem_sel_p`=0, `mem_rd_en_n`=1, `mem_wr_en_n`=1, `mem_dq_oe`=0. `req_ready`=1 and `rd_valid`=0.
- R2: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high. Its address, direction and write byte are latched on that edge, and later changes to the request fields have no effect on the cycle in progress.
- R3: A read selects the device with `mem_rd_en_n`=0 and `mem_wr_en_n`=1 for ACC = max(ceil(tAA/T), ceil(tRC/T)) cycles (9 at the defaults). The byte on `mem_dq_in` is captured on the edge that ends this window. `rd_valid` is high for the single cycle that follows that edge, with the byte on `rd_data`.
- R4: After a read the memory is held in standby for FLT = ceil(tHZ/T) cycles (5 at the defaults) before `req_ready` returns. Total read occupancy is therefore 14 cycles at the defaults.
- R5: A write has three phases: one cycle selected with `mem_wr_en_n`=1; then PLS cycles with `mem_wr_en_n`=0; then END cycles selected with `mem_wr_en_n`=1. PLS = max(ceil(tWP/T), ceil(tDW/T)+1, ceil(tAW/T)-1), which is 7 at the defaults. END = max(1, ceil(tWC/T)-1-PLS), which is 1 at the defaults. `mem_rd_en_n` stays 1 in all three phases.
- R6: `mem_dq_oe` rises one cycle after `mem_wr_en_n` falls and falls with the deselect. It is never high while `mem_rd_en_n` is low or while the device is deselected. While it is high, `mem_dq_out` carries the latched write byte.
- R7: `mem_addr` changes only on a request acceptance edge. It is stable for every cycle in which the device stays selected.
- R8: Every write-enable pulse lasts at least ceil(tWP/T) cycles. The write byte is driven for at least ceil(tDW/T) cycles before the write enable rises.
- R9: A write occupies at least ceil(tWC/T) cycles from acceptance until `req_ready` is high again. This is 9 cycles at the defaults.
- R10: `rd_valid` never lasts more than one cycle, and it never rises because of a write.
- R11: A request held valid while the block is busy is taken on the first idle cycle, exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Request byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W (8) | Byte read |
| mem_addr | output | ADDR_W (13) | Memory address |
| mem_sel_n | output | 1 | Active-low device select |
| mem_sel_p | output | 1 | Active-high device select |
| mem_rd_en_n | output | 1 | Active-low output enable of the device |
| mem_wr_en_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W (8) | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Enables the block's drivers on the shared bus |
| mem_dq_in | input | DATA_W (8) | Byte read from the shared bus |

## Verification
Two events can land in the same cycle: the return to idle and the acceptance of the next request. The bench provokes this by holding a read request valid while a write is still in flight. It then checks that the read starts on the first idle cycle and returns the byte just written. The same held request also exercises R7, because the address may change only on the edge where the select pair re-asserts, never while the write enable is low. A behavioural RAM in the bench checks that edge and also checks for bus contention. It returns junk until the access time has elapsed, so a controller that samples one edge early reads the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_FLT,
    ST_WR_ADR,
    ST_WR_PLS,
    ST_WR_END
  } seq_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // an expired timer stays expired until reloaded (R5 phase lengths rely on it)
  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned ACC_CYC = 9,
  parameter int unsigned FLT_CYC = 5,
  parameter int unsigned PLS_CYC = 7,
  parameter int unsigned END_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             accept,
  output logic             sample
);

  localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_FLT = CNT_W'(FLT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PLS = CNT_W'(PLS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_END = CNT_W'(END_CYC - 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    sample   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        load   = 1'b1;
        if (req_write) begin
          state_d  = ST_WR_ADR;
          load_val = '0;
        end else begin
          state_d  = ST_RD_ACC;
          load_val = LD_ACC;
        end
      end
      ST_RD_ACC: if (expired) begin
        state_d  = ST_RD_FLT;
        load     = 1'b1;
        load_val = LD_FLT;
        sample   = 1'b1;
      end
      ST_RD_FLT: if (expired) state_d = ST_IDLE;
      ST_WR_ADR: if (expired) begin
        state_d  = ST_WR_PLS;
        load     = 1'b1;
        load_val = LD_PLS;
      end
      ST_WR_PLS: if (expired) begin
        state_d  = ST_WR_END;
        load     = 1'b1;
        load_val = LD_END;
      end
      ST_WR_END: if (expired) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 7,
  parameter int unsigned DW_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_rd_en_n,
  output logic              mem_wr_en_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic sel_d, q_in_wr, d_in_wr;
  logic ready_q, sel_q, oe_n_q, we_n_q, dq_oe_q, rdv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;

  always_comb begin
    sel_d   = (state_d == ST_RD_ACC) || (state_d == ST_WR_ADR) ||
              (state_d == ST_WR_PLS) || (state_d == ST_WR_END);
    q_in_wr = (state_q == ST_WR_PLS) || (state_q == ST_WR_END);
    d_in_wr = (state_d == ST_WR_PLS) || (state_d == ST_WR_END);
  end

  // every memory pin comes straight from a flop: no decode glitches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      sel_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      rdv_q   <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      ready_q <= (state_d == ST_IDLE);
      sel_q   <= sel_d;
      oe_n_q  <= (state_d != ST_RD_ACC);
      we_n_q  <= (state_d != ST_WR_PLS);
      dq_oe_q <= q_in_wr && d_in_wr;
      rdv_q   <= sample;
      if (accept) begin
        addr_q <= req_addr;
        wdat_q <= req_wdata;
      end
      if (sample) rdat_q <= mem_dq_in;
    end
  end

  assign req_ready   = ready_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdat_q;
  assign mem_addr    = addr_q;
  assign mem_sel_n   = !sel_q;
  assign mem_sel_p   = sel_q;
  assign mem_rd_en_n = oe_n_q;
  assign mem_wr_en_n = we_n_q;
  assign mem_dq_out  = wdat_q;
  assign mem_dq_oe   = dq_oe_q;

  // counters for the pulse-width and data-setup windows
  logic [31:0] wlo_cnt, dsu_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlo_cnt <= '0;
      dsu_cnt <= '0;
    end else begin
      wlo_cnt <= !we_n_q ? wlo_cnt + 1 : '0;
      dsu_cnt <= (!we_n_q && dq_oe_q) ? dsu_cnt + 1 : '0;
    end
  end

  assert_ready_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel_p && mem_wr_en_n));
  assert_rdvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_rd_en_n));
  assert_no_rd_en_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_en_n |-> (mem_rd_en_n && !mem_sel_n && mem_sel_p));
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_rd_en_n && !mem_sel_n));
  assert_drive_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_en_n) |-> !mem_dq_oe);
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en_n) |-> (wlo_cnt >= WP_CYC));
  assert_data_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en_n) |-> (dsu_cnt >= DW_CYC));
  assert_rdvalid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 8,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_HZ_NS = 35,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_AW_NS = 60,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_DW_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_rd_en_n,
  output logic              mem_wr_en_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned DW_CYC  = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int unsigned AW_CYC  = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned ACC_CYC = max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned FLT_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  // drivers start one cycle into the pulse, so setup needs one extra cycle
  localparam int unsigned PLS_CYC = max2(max2(WP_CYC, DW_CYC + 1), (AW_CYC > 1) ? AW_CYC - 1 : 1);
  localparam int unsigned END_CYC = (WC_CYC > PLS_CYC + 2) ? WC_CYC - 1 - PLS_CYC : 1;
  localparam int unsigned MAX_CYC = max2(max2(ACC_CYC, FLT_CYC), max2(PLS_CYC, END_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic       accept, sample;

  sram_seq #(
    .CNT_W   (CNT_W),
    .ACC_CYC (ACC_CYC),
    .FLT_CYC (FLT_CYC),
    .PLS_CYC (PLS_CYC),
    .END_CYC (END_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .sample    (sample)
  );

  sram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WP_CYC (WP_CYC),
    .DW_CYC (DW_CYC)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .state_d     (state_d),
    .accept      (accept),
    .sample      (sample),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_dq_in   (mem_dq_in),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_sel_n   (mem_sel_n),
    .mem_sel_p   (mem_sel_p),
    .mem_rd_en_n (mem_rd_en_n),
    .mem_wr_en_n (mem_wr_en_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe)
  );

  // write occupancy covers the minimum write cycle (R9)
  assert_write_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !req_ready);

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  // expected cycle counts at an 8 ns clock, worked out from the ns limits
  localparam int B_ACC = 9;  // ceil(70/8)
  localparam int B_FLT = 5;  // ceil(35/8)
  localparam int B_PLS = 7;  // max(ceil(50/8), ceil(30/8)+1, ceil(60/8)-1)
  localparam int B_END = 1;  // max(1, 9-1-7)
  localparam int B_WP  = 7;
  localparam int B_DW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel_p, mem_rd_en_n, mem_wr_en_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_in = 8'hA5;

  always #4 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p), .mem_rd_en_n(mem_rd_en_n),
    .mem_wr_en_n(mem_wr_en_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural RAM ----------------
  logic [7:0] mdl [int];
  logic [7:0] refm [int];
  int acc_cnt = 0, lo_cnt = 0, su_cnt = 0;
  bit prev_sel = 0, prev_we_n = 1;
  logic [12:0] prev_addr = '0;
  logic [7:0]  last_d = '0;

  always @(negedge clk) begin
    bit sel, drv;
    if (rst_n) begin
      sel = !mem_sel_n && mem_sel_p;
      drv = sel && !mem_rd_en_n && mem_wr_en_n;
      if (drv && mem_dq_oe) chk(0, "R6 bus contention", 1, 0);
      if (mem_dq_oe && !sel) chk(0, "R6 drive while deselected", 1, 0);
      if (sel && prev_sel && (!mem_wr_en_n || !prev_we_n) && mem_addr != prev_addr)
        chk(0, "R7 address moved during write", int'(mem_addr), int'(prev_addr));
      acc_cnt = drv ? acc_cnt + 1 : 0;
      mem_dq_in <= (drv && acc_cnt >= B_ACC) ?
                   (mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00) : 8'hA5;
      if (sel && !mem_wr_en_n) begin
        lo_cnt++;
        if (mem_dq_oe) su_cnt = (su_cnt > 0 && mem_dq_out == last_d) ? su_cnt + 1 : 1;
        else su_cnt = 0;
        last_d = mem_dq_out;
      end else begin
        if (prev_sel && !prev_we_n) begin
          mdl[int'(prev_addr)] = last_d;
          chk(lo_cnt >= B_WP, "R8 write pulse width", lo_cnt, B_WP);
          chk(su_cnt >= B_DW, "R8 data setup", su_cnt, B_DW);
        end
        lo_cnt = 0;
        su_cnt = 0;
      end
      prev_sel = sel; prev_we_n = mem_wr_en_n; prev_addr = mem_addr;
    end else begin
      acc_cnt = 0; lo_cnt = 0; su_cnt = 0; prev_sel = 0; prev_we_n = 1;
    end
  end

  // ---------------- operation tasks ----------------
  task automatic start_op(input bit wr, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);  // acceptance edge
  endtask

  task automatic scramble;
    req_valid = 1'b0; req_addr = ~req_addr; req_wdata = ~req_wdata; req_write = ~req_write;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    int we_lo = 0, oe_hi = 0, rd_seen = 0, rden = 0;
    start_op(1'b1, a, d);
    refm[int'(a)] = d;
    for (int k = 1; k <= 2 + B_PLS + B_END; k++) begin
      @(negedge clk);
      if (k == 1) begin
        scramble();
        chk(req_ready == 0, "R2 ready drops after accept", req_ready, 0);
        chk(!mem_sel_n && mem_sel_p && mem_wr_en_n, "R5 address phase", mem_wr_en_n, 1);
      end
      if (!mem_wr_en_n) we_lo++;
      if (mem_dq_oe) begin
        oe_hi++;
        chk(mem_dq_out == d, "R6 write byte on bus", mem_dq_out, d);
      end
      if (!mem_rd_en_n) rden++;
      if (rd_valid) rd_seen++;
      if (k == 1 + B_PLS + B_END)
        chk(req_ready == 0, "R9 still busy", req_ready, 0);
    end
    chk(req_ready == 1, "R9 ready after write cycle", req_ready, 1);
    chk(mem_sel_n && !mem_sel_p && !mem_dq_oe, "R1 standby after write", mem_sel_n, 1);
    chk(we_lo == B_PLS, "R5 pulse length", we_lo, B_PLS);
    chk(oe_hi == B_PLS, "R6 driver window", oe_hi, B_PLS);
    chk(rden == 0, "R5 read enable high in write", rden, 0);
    chk(rd_seen == 0, "R10 no strobe on write", rd_seen, 0);
  endtask

  task automatic do_read(input logic [12:0] a, input logic [7:0] exp);
    int when = 0, cnt = 0;
    logic [7:0] got = '0;
    start_op(1'b0, a, 8'h00);
    for (int k = 1; k <= 1 + B_ACC + B_FLT; k++) begin
      @(negedge clk);
      if (k == 1) scramble();
      if (k <= B_ACC)
        chk(!mem_rd_en_n && mem_wr_en_n && !mem_sel_n, "R3 read window", mem_rd_en_n, 0);
      if (rd_valid) begin cnt++; when = k; got = rd_data; end
      if (k == B_ACC + B_FLT)
        chk(req_ready == 0 && mem_sel_n, "R4 float wait", req_ready, 0);
    end
    chk(req_ready == 1, "R4 ready after float", req_ready, 1);
    chk(cnt == 1, "R10 single strobe", cnt, 1);
    chk(when == B_ACC + 1, "R3 strobe cycle", when, B_ACC + 1);
    chk(got == exp, "R3 read data", got, exp);
  endtask

  // {write, addr[12:0], wdata[7:0], expected read[7:0]}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 13'h0000, 8'h3C, 8'h00},
    {1'b1, 13'h1FFF, 8'hC3, 8'h00},
    {1'b1, 13'h0AAA, 8'h55, 8'h00},
    {1'b0, 13'h0000, 8'h00, 8'h3C},
    {1'b0, 13'h1FFF, 8'h00, 8'hC3},
    {1'b1, 13'h0000, 8'h7E, 8'h00},
    {1'b0, 13'h0000, 8'h00, 8'h7E},
    {1'b0, 13'h0AAA, 8'h00, 8'h55}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && mem_sel_n && !mem_sel_p && mem_rd_en_n && mem_wr_en_n
        && !mem_dq_oe && !rd_valid, "R1 reset state", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][29]) do_write(VEC[i][28:16], VEC[i][15:8]);
      else begin
        do_read(VEC[i][28:16], VEC[i][7:0]);
        chk(refm[int'(VEC[i][28:16])] == VEC[i][7:0], "R2 reference array",
            refm[int'(VEC[i][28:16])], VEC[i][7:0]);
      end
    end

    // R11: read held valid during a write, taken on the first idle cycle
    begin
      int k = 0, accepted = 0;
      logic [7:0] got = '0;
      start_op(1'b1, 13'h0123, 8'h9D);
      @(negedge clk);
      req_write = 1'b0; req_addr = 13'h0123; req_wdata = 8'h00;
      while (!rd_valid && k < 60) begin
        @(negedge clk); k++;
        if (req_ready && req_valid) accepted++;
      end
      got = rd_data;
      req_valid = 1'b0;
      chk(accepted == 1, "R11 single acceptance", accepted, 1);
      chk(got == 8'h9D, "R11 chained read data", got, 8'h9D);
      chk(k == B_PLS + B_END + 1 + B_ACC + 1, "R11 chained latency", k, B_PLS + B_END + B_ACC + 2);
      repeat (B_FLT + 2) @(negedge clk);
    end

    // R1: reset in the middle of a read returns to standby
    start_op(1'b0, 13'h0AAA, 8'h00);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_sel_n && mem_rd_en_n && !rd_valid && req_ready, "R1 mid-read reset", mem_sel_n, 1);
    rst_n = 1'b1;
    do_read(13'h0AAA, 8'h55);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule